// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the clocked control core for one phase of a synchronous buck converter. It takes a three-level PWM command and a three-level enable command, both already resolved into 2-bit level codes. It also takes a supply-good flag, a zero-cross comparator flag from the switch node, and two feedback bits reporting that each power FET gate has discharged. From these it produces the enables for the high-side and low-side gate drivers.

Every change of conducting FET passes through an adaptive break-before-make handover. First the outgoing gate is dropped. The block then waits until that gate's feedback reports off, and after that waits a further minimum settle time. A timeout completes the handover if the feedback never arrives.

A mid-level PWM command selects diode emulation: the low side conducts for a fixed blanking interval, and then turns off on the first zero-cross indication. It stays off for as long as the mid command lasts. A mid-level enable parks both gates off so that the low-side body diode brakes the inductor current. A low enable disables the phase, and a supply that is not good holds both gates off.

Top module: `buck_gate_seq`

## Requirements
- R1: Both level inputs use the code 2'b00 = low, 2'b01 = mid, 2'b10 = high. The code 2'b11 is treated exactly as mid.
- R2: While `supply_ok` is 0, both gate enables are 0 from the next clock edge on. When the supply returns, the commanded gate is reached only through a full handover.
- R3: An enable code of mid (braking) or low (disable) drives both gate enables to 0 from the next clock edge on, whatever the PWM code. Restoring a high enable resumes normal handovers.
- R4: On a high PWM command, `ls_gate` drops at the first edge that samples it. `hs_gate` rises DT_MIN edges after the first edge of the handover that samples `ls_off_fb` = 1, and never in the same cycle as, or the cycle after, `ls_gate` high.
- R5: On a low PWM command, `hs_gate` drops at the first edge that samples it. `ls_gate` rises DT_MIN edges after the first edge of the handover that samples `hs_off_fb` = 1.
- R6: On a mid PWM command while the high side conducts, `hs_gate` drops at the first sampling edge, and `ls_gate` rises after the same handover as in R5.
- R7: If the outgoing gate's feedback never reports off, the incoming gate still rises, exactly DT_MAX+1 edges after the edge that began the handover.
- R8: After `ls_gate` rises under a mid PWM command, it stays 1 for at least BLANK_CYC cycles, and `zc_det` has no effect during that interval.
- R9: After blanking, the first edge that samples `zc_det` = 1 drops `ls_gate`. It then stays 0 for as long as PWM remains mid, even if `zc_det` falls again.
- R10: A high or low PWM command clears the zero-cross latch, and the commanded gate turns on again through a normal handover.
- R11: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R12: While `rst_n` is low, both gate enables are 0. Reset takes effect asynchronously and is released synchronously, two edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_code | input | 2 | PWM command level code (R1) |
| en_code | input | 2 | Enable command level code (R1) |
| supply_ok | input | 1 | Driver supply above its lockout threshold |
| zc_det | input | 1 | Switch-node zero-cross comparator result |
| hs_off_fb | input | 1 | High-side gate reported discharged |
| ls_off_fb | input | 1 | Low-side gate reported discharged |
| hs_gate | output | 1 | High-side gate-drive enable |
| ls_gate | output | 1 | Low-side gate-drive enable |

## Verification
The bench holds `zc_det` high from the start of a diode-emulation sequence. A sequencer that ignored blanking would drop the low side on its very first conducting cycle instead of after BLANK_CYC cycles. It also pulses `zc_det` only briefly after blanking, so a design without a real latch would re-enable the low side. Feedback is held asserted-on to separate the adaptive path from the timeout: a design that waited only a fixed time would switch too early, and one without a timeout would hang. The code 2'b11 is exercised on both inputs, so a decoder that mapped it to high or low would either start the wrong FET or ignore the zero cross.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

  typedef enum logic [1:0] {
    LV_LOW  = 2'd0,
    LV_MID  = 2'd1,
    LV_HIGH = 2'd2
  } lvl_e;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_TO_HS = 3'd1,
    ST_HS    = 3'd2,
    ST_TO_LS = 3'd3,
    ST_LS    = 3'd4,
    ST_PARK  = 3'd5
  } seq_st_e;

  // R1: 00 low, 10 high, 01 and 11 mid
  function automatic lvl_e lvl_decode(input logic [1:0] code);
    lvl_e lv;
    case (code)
      2'b00:   lv = LV_LOW;
      2'b10:   lv = LV_HIGH;
      default: lv = LV_MID;
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/gseq_rst_sync.sv
module gseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/gseq_handover.sv
module gseq_handover #(
  parameter int unsigned DT_MIN = 3,
  parameter int unsigned DT_MAX = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic restart,
  input  logic fb_off,
  output logic ready
);

  localparam int unsigned TOP = (DT_MAX > DT_MIN) ? DT_MAX : DT_MIN;
  localparam int unsigned CW  = $clog2(TOP + 2);
  localparam logic [CW-1:0] MIN_C = CW'(DT_MIN);
  localparam logic [CW-1:0] MAX_C = CW'(DT_MAX);

  logic [CW-1:0] settle_q, settle_d;
  logic [CW-1:0] tmo_q, tmo_d;
  logic          cnt_en;

  always_comb begin
    if (restart || !arm) begin
      settle_d = '0;
      tmo_d    = '0;
    end else begin
      tmo_d = (tmo_q >= MAX_C) ? tmo_q : tmo_q + 1'b1;
      if (!fb_off) begin
        settle_d = '0;
      end else begin
        settle_d = (settle_q >= MIN_C) ? settle_q : settle_q + 1'b1;
      end
    end
    cnt_en = arm || (tmo_q != '0) || (settle_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      tmo_q    <= '0;
    end else if (cnt_en) begin
      settle_q <= settle_d;
      tmo_q    <= tmo_d;
    end
  end

  assign ready = arm && ((fb_off && (settle_q >= MIN_C)) || (tmo_q >= MAX_C));

  AST_TMO_FORCES_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && (tmo_q == MAX_C)) |-> restart); // R7

endmodule

// File: rtl/gseq_blanker.sv
module gseq_blanker #(
  parameter int unsigned BLANK_CYC = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic zc_flag,
  output logic blank_done,
  output logic zc_hit
);

  localparam int unsigned CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LAST_C = CW'(BLANK_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    if (!arm) begin
      cnt_d = '0;
    end else begin
      cnt_d = (cnt_q >= LAST_C) ? cnt_q : cnt_q + 1'b1;
    end
    cnt_en = arm || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign blank_done = (cnt_q >= LAST_C);
  assign zc_hit     = arm && blank_done && zc_flag;

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import gseq_pkg::*;
#(
  parameter int unsigned DT_MIN     = 3,
  parameter int unsigned DT_MAX     = 20,
  parameter int unsigned BLANK_CYC  = 35,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_code,
  input  logic [1:0] en_code,
  input  logic       supply_ok,
  input  logic       zc_det,
  input  logic       hs_off_fb,
  input  logic       ls_off_fb,
  output logic       hs_gate,
  output logic       ls_gate
);

  logic    rst_int_n;
  lvl_e    pwm_lv, en_lv;
  logic    active;
  seq_st_e state_q, state_d;
  logic    state_en;
  logic    hs_q, hs_d, ls_q, ls_d;
  logic    ho_arm, ho_restart, ho_fb, ho_ready;
  logic    bl_arm, bl_done, zc_hit;

  gseq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    pwm_lv = lvl_decode(pwm_code);
    en_lv  = lvl_decode(en_code);
    active = supply_ok && (en_lv == LV_HIGH);
  end

  always_comb begin
    ho_arm = (state_q == ST_TO_HS) || (state_q == ST_TO_LS);
    ho_fb  = (state_q == ST_TO_HS) ? ls_off_fb : hs_off_fb;
    bl_arm = active && (state_q == ST_LS) && (pwm_lv == LV_MID);
  end

  gseq_handover #(.DT_MIN(DT_MIN), .DT_MAX(DT_MAX)) u_handover (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .arm     (ho_arm),
    .restart (ho_restart),
    .fb_off  (ho_fb),
    .ready   (ho_ready)
  );

  gseq_blanker #(.BLANK_CYC(BLANK_CYC)) u_blanker (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .arm        (bl_arm),
    .zc_flag    (zc_det),
    .blank_done (bl_done),
    .zc_hit     (zc_hit)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    if (!active) begin
      state_d = ST_OFF;
    end else if (pwm_lv == LV_HIGH) begin
      case (state_q)
        ST_HS:    state_d = ST_HS;
        ST_TO_HS: state_d = ho_ready ? ST_HS : ST_TO_HS;
        default:  state_d = ST_TO_HS;
      endcase
    end else begin
      case (state_q)
        ST_LS:    state_d = ((pwm_lv == LV_MID) && zc_hit) ? ST_PARK : ST_LS;
        ST_TO_LS: state_d = ho_ready ? ST_LS : ST_TO_LS;
        ST_PARK:  state_d = (pwm_lv == LV_MID) ? ST_PARK : ST_TO_LS;
        default:  state_d = ST_TO_LS;
      endcase
    end
    ho_restart = (state_d != state_q);
    state_en   = ho_restart;
    hs_d       = (state_d == ST_HS);
    ls_d       = (state_d == ST_LS);
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_OFF;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
    end
  end

  assign hs_gate = hs_q;
  assign ls_gate = ls_q;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(hs_q && ls_q)); // R11
  AST_SUPPLY_GATE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !supply_ok |=> (!hs_q && !ls_q)); // R2
  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en_lv != LV_HIGH) |=> (!hs_q && !ls_q)); // R3
  AST_HS_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(hs_q) |-> !$past(ls_q)); // R4
  AST_LS_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ls_q) |-> !$past(hs_q)); // R5
  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bl_arm && !bl_done) |=> ls_q); // R8

endmodule

// File: tb/buck_gate_seq_tb.sv
module buck_gate_seq_tb;

  localparam int unsigned DT_MIN    = 3;
  localparam int unsigned DT_MAX    = 20;
  localparam int unsigned BLANK_CYC = 35;
  localparam int unsigned WD_LIMIT  = 20000;

  logic       clk;
  logic       rst_n;
  logic [1:0] pwm_code;
  logic [1:0] en_code;
  logic       supply_ok;
  logic       zc_det;
  logic       hold_hs, hold_ls;
  logic       hs_off_fb, ls_off_fb;
  logic       hs_gate, ls_gate;

  int checks;
  int errors;
  int overlaps;
  int cycles;
  bit done;

  assign hs_off_fb = hold_hs ? 1'b0 : !hs_gate;
  assign ls_off_fb = hold_ls ? 1'b0 : !ls_gate;

  buck_gate_seq #(
    .DT_MIN    (DT_MIN),
    .DT_MAX    (DT_MAX),
    .BLANK_CYC (BLANK_CYC)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_code  (pwm_code),
    .en_code   (en_code),
    .supply_ok (supply_ok),
    .zc_det    (zc_det),
    .hs_off_fb (hs_off_fb),
    .ls_off_fb (ls_off_fb),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (hs_gate && ls_gate) overlaps++;
    if (cycles >= WD_LIMIT && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic t_reset();
    tick(3);
    chk("R12 hs in reset", hs_gate, 1'b0);
    chk("R12 ls in reset", ls_gate, 1'b0);
    en_code = 2'b00;
    rst_n   = 1'b1;
    tick(4);
    chk("R12 hs after release disabled", hs_gate, 1'b0);
    chk("R3 ls disabled", ls_gate, 1'b0);
  endtask

  task automatic t_low_start();
    en_code  = 2'b10;
    pwm_code = 2'b00;
    tick(DT_MIN + 1);
    chk("R5 ls waits non-overlap", ls_gate, 1'b0);
    tick(1);
    chk("R5 ls on", ls_gate, 1'b1);
    chk("R5 hs off", hs_gate, 1'b0);
  endtask

  task automatic t_high();
    pwm_code = 2'b10;
    tick(1);
    chk("R4 ls drops at once", ls_gate, 1'b0);
    chk("R4 hs not yet", hs_gate, 1'b0);
    tick(DT_MIN);
    chk("R4 hs still waiting", hs_gate, 1'b0);
    tick(1);
    chk("R4 hs on", hs_gate, 1'b1);
  endtask

  task automatic t_mid_blank();
    pwm_code = 2'b01;
    zc_det   = 1'b1;
    tick(1);
    chk("R6 hs drops at once", hs_gate, 1'b0);
    tick(DT_MIN);
    chk("R6 ls waits", ls_gate, 1'b0);
    tick(1);
    chk("R6 ls on", ls_gate, 1'b1);
    tick(BLANK_CYC - 1);
    chk("R8 ls held through blanking", ls_gate, 1'b1);
    tick(1);
    chk("R9 ls off on zero cross", ls_gate, 1'b0);
    zc_det = 1'b0;
    tick(5);
    chk("R9 ls latched off", ls_gate, 1'b0);
    chk("R9 hs stays off", hs_gate, 1'b0);
  endtask

  task automatic t_low_from_park();
    pwm_code = 2'b00;
    tick(DT_MIN + 1);
    chk("R10 ls waits", ls_gate, 1'b0);
    tick(1);
    chk("R10 ls on after low", ls_gate, 1'b1);
  endtask

  task automatic t_mid_late_zc();
    pwm_code = 2'b11;
    zc_det   = 1'b0;
    tick(BLANK_CYC + 10);
    chk("R1 ls stays on with code 11", ls_gate, 1'b1);
    zc_det = 1'b1;
    tick(1);
    chk("R9 R1 ls off on late zero cross", ls_gate, 1'b0);
    zc_det = 1'b0;
    tick(3);
    chk("R9 ls remains off", ls_gate, 1'b0);
  endtask

  task automatic t_high_from_park();
    pwm_code = 2'b10;
    tick(DT_MIN + 1);
    chk("R10 hs waits", hs_gate, 1'b0);
    tick(1);
    chk("R10 hs on after high", hs_gate, 1'b1);
  endtask

  task automatic t_timeout();
    hold_hs  = 1'b1;
    pwm_code = 2'b00;
    tick(1);
    chk("R7 hs drops", hs_gate, 1'b0);
    tick(DT_MAX);
    chk("R7 ls waits for timeout", ls_gate, 1'b0);
    tick(1);
    chk("R7 ls forced on", ls_gate, 1'b1);
    hold_hs = 1'b0;
  endtask

  task automatic t_adaptive();
    hold_ls  = 1'b1;
    pwm_code = 2'b10;
    tick(7);
    chk("R4 hs held by feedback", hs_gate, 1'b0);
    hold_ls = 1'b0;
    tick(DT_MIN);
    chk("R4 hs settle wait", hs_gate, 1'b0);
    tick(1);
    chk("R4 hs on after feedback", hs_gate, 1'b1);
  endtask

  task automatic t_supply();
    supply_ok = 1'b0;
    tick(1);
    chk("R2 hs off on lockout", hs_gate, 1'b0);
    pwm_code = 2'b00;
    tick(5);
    chk("R2 ls off on lockout", ls_gate, 1'b0);
    pwm_code  = 2'b10;
    supply_ok = 1'b1;
    tick(DT_MIN + 1);
    chk("R2 hs waits after supply", hs_gate, 1'b0);
    tick(1);
    chk("R2 hs on after supply", hs_gate, 1'b1);
  endtask

  task automatic t_enable();
    en_code = 2'b01;
    tick(1);
    chk("R3 brake hs off", hs_gate, 1'b0);
    chk("R3 brake ls off", ls_gate, 1'b0);
    pwm_code = 2'b00;
    tick(6);
    chk("R3 brake ignores pwm low", ls_gate, 1'b0);
    pwm_code = 2'b01;
    en_code  = 2'b11;
    tick(4);
    chk("R1 R3 enable code 11 brakes", ls_gate, 1'b0);
    en_code = 2'b00;
    tick(3);
    chk("R3 disable ls", ls_gate, 1'b0);
    chk("R3 disable hs", hs_gate, 1'b0);
    en_code  = 2'b10;
    pwm_code = 2'b00;
    tick(DT_MIN + 1);
    chk("R3 resume waits", ls_gate, 1'b0);
    tick(1);
    chk("R3 resume ls on", ls_gate, 1'b1);
  endtask

  initial begin
    checks    = 0;
    errors    = 0;
    overlaps  = 0;
    cycles    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    pwm_code  = 2'b10;
    en_code   = 2'b10;
    supply_ok = 1'b1;
    zc_det    = 1'b0;
    hold_hs   = 1'b0;
    hold_ls   = 1'b0;
    t_reset();
    t_low_start();
    t_high();
    t_mid_blank();
    t_low_from_park();
    t_mid_late_zc();
    t_high_from_park();
    t_timeout();
    t_adaptive();
    t_supply();
    t_enable();
    checks++;
    if (overlaps != 0) begin
      errors++;
      $display("FAIL R11 overlap cycles actual %0d expected 0", overlaps);
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule